// File: doc/BRIEF.md
# Serial Flash Pin Front End

This block is the device-side pin logic of a serial NOR flash. It watches chip select, the serial clock and four data lanes. Lane 0 is the serial input, lane 1 the serial output, lane 2 the active-low write-protect pin and lane 3 the active-low hold pin. All pins are brought into the system clock domain through a synchronizer. Serial clock edges are found there, so every decision the block makes is ordinary synchronous logic.

A small command tracker frames each selected transfer. The first byte is the opcode, a fixed number of address bytes follow, and then comes a data phase that either receives bytes or returns bytes. Read bytes come from a memory-side byte port. When the quad-enable configuration input is set, lanes 2 and 3 stop acting as protect and hold pins and carry data instead, so quad commands move a nibble per clock.

The hold pin can pause a transfer in the middle of a byte without deselecting the device. While a hold is in force, clock edges are ignored and all lanes are released. The transfer then picks up at the exact bit where it stopped.

Top module: `sflash_pin_fe`

## Requirements
- R1: Outside a read data phase, each rising serial clock edge shifts lane 0 into the receive byte, most significant bit first. After eight such edges, `rx_byte` holds the byte and `rx_valid` pulses high for one cycle.
- R2: The first byte after select is taken as the opcode and the next ADDR_BYTES (default 3) bytes as address. Opcode 8'h03 starts a single-lane read. Opcode 8'h6B starts a quad read and opcode 8'h32 a quad write. Any other opcode keeps receiving bytes on lane 0 and never drives a lane.
- R3: In a single-lane read, each falling clock edge drives the next data bit on lane 1 (`io_out[1]`), most significant bit first, with `io_oe` equal to 4'b0010.
- R4: With `qe` high, opcode 8'h6B drives one nibble per falling edge on `io_out[3:0]`, high nibble first, with `io_oe` = 4'b1111. Opcode 8'h32 captures one nibble per rising edge, high nibble first. `quad_active` is high during these data phases. With `qe` low, both opcodes move data on a single lane.
- R5: A hold begins only when lane 3 falls while the device is selected and the clock is low. A fall of lane 3 while the clock is high is ignored, and it stays ignored for as long as the pin remains low.
- R6: During a hold, clock edges and lane 0 data have no effect on the transfer, and `io_oe` is 4'b0000.
- R7: A hold ends when lane 3 is high while the clock is low. The transfer resumes at the same bit, with no bit lost or repeated.
- R8: While `qe` is high, no hold can begin, and lane 3 going low does not disturb a transfer.
- R9: Deselecting (`cs_n` high) clears the bit count, the command state and any hold, and sets `io_oe` to 4'b0000. The next selection starts with a fresh opcode.
- R10: `hw_lock` is high exactly when `qe` is low and lane 2 (write protect, active low) is low.
- R11: `rd_req` is a one-cycle pulse, and `rd_data` must be valid in that same cycle. The first request follows the last address byte of a read. Each further request is made as an output byte starts, to prefetch the following byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qe | input | 1 | Quad-enable configuration bit |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| io_in | input | 4 | Lane inputs: 0 serial in, 1 serial out, 2 write protect, 3 hold |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Per-lane output enable; 0 means high impedance |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| quad_active | output | 1 | Current data phase uses four lanes |
| rd_req | output | 1 | Request for the next read byte |
| rd_data | input | 8 | Read byte, valid in the `rd_req` cycle |
| hw_lock | output | 1 | Hardware write lock from the protect pin |

## Verification
The bench pauses a read and an address byte in the middle of a byte and toggles the clock and lane 0 while held. A design that counted those edges, or failed to release the output lane, would return shifted data or show a driven lane during the pause. A hold request made while the clock is high must be ignored; a design that armed the hold late would stall and lose the rest of the byte. The bench also checks nibble order and lane enables for quad reads and writes, the fallback to a single lane when quad enable is clear, the data pattern of lane 3 toggling in quad mode, and a deselect in the middle of a byte. A design that kept stale bit counts across these cases would misframe the next opcode.

// File: rtl/sfpf_pkg.sv
package sfpf_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DIN, PH_DOUT} phase_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_QREAD = 8'h6B;
  localparam logic [7:0] OP_QPROG = 8'h32;

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_READ) || (op == OP_QREAD);
  endfunction

  function automatic logic op_is_quad(input logic [7:0] op);
    return (op == OP_QREAD) || (op == OP_QPROG);
  endfunction

  // lanes moved per serial clock
  function automatic int unsigned bits_per_clk(input logic quad);
    return quad ? NIB_W : 1;
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sr, input logic [3:0] lanes,
                                          input logic quad);
    return quad ? {sr[3:0], lanes} : {sr[6:0], lanes[0]};
  endfunction

  function automatic logic [3:0] lane_drive(input logic [7:0] src, input logic quad);
    return quad ? src[7:4] : {2'b00, src[7], 1'b0};
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] src, input logic quad);
    return quad ? {src[3:0], 4'h0} : {src[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/sfpf_sync.sv
module sfpf_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sfpf_hold.sv
module sfpf_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic qe,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held
);
  logic hold_d;
  logic hold_fall;
  logic start_ok;
  logic end_ok;

  assign hold_fall = hold_d && !hold_n_s;
  assign start_ok  = hold_fall && !sck_s;
  assign end_ok    = hold_n_s && !sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d <= 1'b1;
      held   <= 1'b0;
    end else begin
      hold_d <= hold_n_s;
      if (!cs_act || qe) held <= 1'b0;
      else if (held)     held <= !end_ok;
      else               held <= start_ok;
    end
  end

  // R5: a hold only starts while selected with the clock low
  p_hold_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!sck_s && cs_act && !qe));
  // R7: a hold only ends with the pin high and the clock low
  p_hold_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && $past(cs_act) && !$past(qe)) |-> $past(hold_n_s && !sck_s));
  p_no_hold_quad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    qe |=> !held);
  p_hold_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !held);
endmodule

// File: rtl/sfpf_track.sv
module sfpf_track import sfpf_pkg::*; #(
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       qe,
  input  logic       byte_done,
  input  logic [7:0] byte_in,
  output phase_e     phase,
  output logic       quad,
  output logic       enter_out
);
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

  logic [ACNT_W-1:0] acnt;
  logic [7:0]        op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      acnt      <= '0;
      op        <= '0;
      enter_out <= 1'b0;
    end else if (!cs_act) begin
      phase     <= PH_CMD;
      acnt      <= '0;
      op        <= '0;
      enter_out <= 1'b0;
    end else begin
      enter_out <= 1'b0;
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            op    <= byte_in;
            acnt  <= '0;
            phase <= PH_ADDR;
          end
          PH_ADDR: begin
            if (acnt == ACNT_W'(ADDR_BYTES - 1)) begin
              phase     <= op_is_read(op) ? PH_DOUT : PH_DIN;
              enter_out <= op_is_read(op);
            end else begin
              acnt <= acnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign quad = qe && op_is_quad(op) && (phase == PH_DIN || phase == PH_DOUT);

  // R9: deselect returns the tracker to the opcode phase
  p_cmd_on_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CMD));
endmodule

// File: rtl/sflash_pin_fe.sv
module sflash_pin_fe import sfpf_pkg::*; #(
  parameter int ADDR_BYTES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qe,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] io_in,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       quad_active,
  output logic       rd_req,
  input  logic [7:0] rd_data,
  output logic       hw_lock
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PIN_W = 2 + NIB_W;

  // synchronized pins
  logic [PIN_W-1:0] pins_s;
  logic             cs_n_s, sck_s;
  logic [3:0]       io_s;

  sfpf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(6'b10_1111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, io_in}), .q(pins_s));
  assign {cs_n_s, sck_s, io_s} = pins_s;

  // named events
  logic cs_act, sck_d, sck_rise, sck_fall, held, rise_ev, fall_ev;
  assign cs_act   = !cs_n_s;
  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;
  assign rise_ev  = sck_rise && cs_act && !held;
  assign fall_ev  = sck_fall && cs_act && !held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;

  sfpf_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .qe(qe),
    .sck_s(sck_s), .hold_n_s(io_s[3]), .held(held));

  phase_e     phase;
  logic       quad, enter_out, byte_done;
  logic [7:0] in_sr, in_next;
  logic [CNT_W-1:0] in_cnt, step;
  logic       in_phase, out_phase;

  sfpf_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .qe(qe),
    .byte_done(byte_done), .byte_in(in_next),
    .phase(phase), .quad(quad), .enter_out(enter_out));

  assign step      = CNT_W'(bits_per_clk(quad));
  assign in_phase  = (phase != PH_DOUT);
  assign out_phase = (phase == PH_DOUT);
  assign in_next   = shift_in(in_sr, io_s, quad);
  assign byte_done = rise_ev && in_phase && ((in_cnt + step) == CNT_W'(BYTE_W));

  // receive path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr    <= '0;
      in_cnt   <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= byte_done;
      if (byte_done) rx_byte <= in_next;
      if (!cs_act) begin
        in_cnt <= '0;
      end else if (rise_ev && in_phase) begin
        in_sr  <= in_next;
        in_cnt <= byte_done ? '0 : in_cnt + step;
      end
    end
  end

  // transmit path with one-byte prefetch
  logic [7:0]       out_sr, nxt_byte, out_src;
  logic [CNT_W-1:0] out_cnt;
  logic [3:0]       dout;
  logic             out_start;

  assign out_start = fall_ev && out_phase && (out_cnt == '0);
  assign out_src   = out_start ? nxt_byte : out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sr   <= '0;
      nxt_byte <= '0;
      out_cnt  <= '0;
      dout     <= '0;
      rd_req   <= 1'b0;
    end else if (!cs_act) begin
      out_cnt <= '0;
      dout    <= '0;
      rd_req  <= 1'b0;
    end else begin
      rd_req <= enter_out || out_start;
      if (rd_req) nxt_byte <= rd_data;
      if (fall_ev && out_phase) begin
        dout    <= lane_drive(out_src, quad);
        out_sr  <= shift_out(out_src, quad);
        out_cnt <= out_start ? CNT_W'(BYTE_W) - step : out_cnt - step;
      end
    end
  end

  assign io_out      = dout;
  assign io_oe       = (cs_act && out_phase && !held) ? (quad ? 4'hF : 4'h2) : 4'h0;
  assign quad_active = quad;
  assign hw_lock     = !qe && !io_s[2];

  // R6: bit position frozen across a hold
  p_freeze_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(in_cnt) && $stable(out_cnt)));
  // R9: one cycle after deselect, nothing is driven or requested
  p_hiz_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_act) |-> (io_oe == 4'h0 && !rd_req));
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  p_rx_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(sck_s) && !$past(sck_d)));
  p_quad_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'hF) |-> qe);
endmodule

// File: tb/tb_sflash_pin_fe.sv
`timescale 1ns/1ps
module tb_sflash_pin_fe;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qe = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] io_in = 4'hF;
  logic [3:0] io_out, io_oe;
  logic       rx_valid, quad_active, rd_req, hw_lock;
  logic [7:0] rx_byte, rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int rd_idx = 0;
  int rd_base = 0;
  logic [7:0] rx_q[$];

  always #5 clk = ~clk;

  sflash_pin_fe dut (
    .clk(clk), .rst_n(rst_n), .qe(qe), .cs_n(cs_n), .sck(sck), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .quad_active(quad_active), .rd_req(rd_req), .rd_data(rd_data), .hw_lock(hw_lock));

  function automatic logic [7:0] mem_val(input int k);
    return 8'((k * 37) ^ 90);
  endfunction

  // memory model: rd_data valid in the request cycle
  assign rd_data = mem_val(rd_idx - rd_base);
  always @(posedge clk) if (rd_req) rd_idx <= rd_idx + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for received bytes (R1)
  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_q.size() == 0) check(0, "R1 unexpected rx", rx_byte, 0);
      else begin
        logic [7:0] e;
        e = rx_q.pop_front();
        check(rx_byte == e, "R1 rx byte", rx_byte, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_hold();
    tick(2);
    io_in[3] = 1'b0;
    tick(HP);
    check(io_oe == 4'h0, "R6 lanes released in hold", io_oe, 0);
    repeat (3) begin
      io_in[0] = ~io_in[0];
      sck = 1'b1; tick(HP);
      sck = 1'b0; tick(HP);
    end
    io_in[3] = 1'b1;
    tick(HP);
  endtask

  // single-lane byte out; lo_at: hold after that bit, hi_at: hold request while clock high
  task automatic send_s(input logic [7:0] b, input int lo_at = -1, input int hi_at = -1,
                        input bit io3_wiggle = 0);
    rx_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      io_in[0] = b[i];
      if (io3_wiggle && i == 5) io_in[3] = 1'b0;
      if (io3_wiggle && i == 1) io_in[3] = 1'b1;
      tick(HP);
      sck = 1'b1;
      if (i == hi_at) begin tick(2); io_in[3] = 1'b0; tick(HP - 2); end
      else tick(HP);
      sck = 1'b0;
      if (i == lo_at) do_hold();
    end
    if (hi_at >= 0) io_in[3] = 1'b1;
  endtask

  task automatic send_q(input logic [7:0] b);
    rx_q.push_back(b);
    io_in = b[7:4]; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
    io_in = b[3:0]; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
    io_in = 4'hF;
  endtask

  task automatic recv(input bit quad, input logic [7:0] exp, input string req,
                      input int lo_at = -1, input int hi_at = -1);
    logic [7:0] got;
    int n;
    n = quad ? 2 : 8;
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      tick(HP);
      check(io_oe == (quad ? 4'hF : 4'h2), {req, " lane enable"}, io_oe, quad ? 15 : 2);
      got = quad ? {got[3:0], io_out} : {got[6:0], io_out[1]};
      sck = 1'b1;
      if (i == hi_at) begin tick(2); io_in[3] = 1'b0; tick(HP - 2); end
      else tick(HP);
      sck = 1'b0;
      if (i == lo_at) do_hold();
    end
    if (hi_at >= 0) io_in[3] = 1'b1;
    check(got == exp, req, got, exp);
  endtask

  task automatic begin_xfer();
    cs_n = 1'b0;
    rd_base = rd_idx;
    tick(HP);
  endtask

  task automatic end_xfer();
    tick(HP);
    cs_n = 1'b1;
    tick(HP);
    check(io_oe == 4'h0, "R9 released after deselect", io_oe, 0);
  endtask

  task automatic cmd(input logic [7:0] op);
    send_s(op); send_s(8'h12); send_s(8'h34); send_s(8'h56);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check(io_oe == 4'h0 && !rx_valid && !rd_req, "R9 reset idle", io_oe, 0);
    check(!hw_lock && !quad_active, "R10 reset lock clear", hw_lock, 0);

    // R3: single read, three bytes
    begin_xfer(); cmd(8'h03);
    recv(0, mem_val(0), "R3 read byte0");
    recv(0, mem_val(1), "R3 read byte1");
    recv(0, mem_val(2), "R11 prefetch byte2");
    end_xfer();

    // R2: other opcode receives data and never drives
    begin_xfer(); cmd(8'h02); send_s(8'hC3); send_s(8'h5A);
    check(io_oe == 4'h0, "R2 no drive on write", io_oe, 0);
    end_xfer();

    // R4: quad read and quad write with qe set
    qe = 1'b1;
    begin_xfer(); cmd(8'h6B);
    recv(1, mem_val(0), "R4 quad read byte0");
    check(quad_active, "R4 quad flag", quad_active, 1);
    recv(1, mem_val(1), "R4 quad read byte1");
    end_xfer();
    begin_xfer(); cmd(8'h32); send_q(8'hA7); send_q(8'h3E);
    check(quad_active, "R4 quad write flag", quad_active, 1);
    end_xfer();

    // R8: lane 3 low during a transfer in quad mode does not stall it
    begin_xfer(); cmd(8'h02); send_s(8'h96, -1, -1, 1); send_s(8'h4B);
    end_xfer();
    qe = 1'b0;

    // R4: quad opcode without qe falls back to one lane
    begin_xfer(); cmd(8'h6B);
    recv(0, mem_val(0), "R4 fallback read");
    check(!quad_active, "R4 fallback flag", quad_active, 0);
    end_xfer();

    // R6/R7: hold inside an address byte and inside a read byte
    begin_xfer();
    send_s(8'h03); send_s(8'h12, 4); send_s(8'h34); send_s(8'h56);
    recv(0, mem_val(0), "R7 read resumes after hold", 3);
    recv(0, mem_val(1), "R7 following byte");
    end_xfer();

    // R5: hold request while clock high is ignored
    begin_xfer();
    send_s(8'h03, -1, 5); send_s(8'h12); send_s(8'h34); send_s(8'h56);
    recv(0, mem_val(0), "R5 high-clock hold ignored", -1, 4);
    end_xfer();

    // R9: deselect mid-byte, then a fresh command
    begin_xfer();
    for (int i = 0; i < 4; i++) begin
      io_in[0] = 1'b1; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
    end
    end_xfer();
    begin_xfer(); cmd(8'h03);
    recv(0, mem_val(0), "R9 fresh framing after deselect");
    end_xfer();

    // R10: protect pin gating
    io_in[2] = 1'b0; tick(5);
    check(hw_lock, "R10 lock with pin low", hw_lock, 1);
    qe = 1'b1; tick(2);
    check(!hw_lock, "R10 no lock in quad", hw_lock, 0);
    qe = 1'b0; io_in[2] = 1'b1; tick(5);
    check(!hw_lock, "R10 lock released", hw_lock, 0);

    tick(10);
    check(rx_q.size() == 0, "R1 all bytes received", rx_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule